// File: doc/BRIEF.md
# NAND Flash Array Emulator

This block models a small NAND flash array so that a flash controller can be built and tested against realistic storage rules without a physical device. A controller sends one command at a time: read a page, program a page, or erase a block. Program data arrives as word beats after the command. Read data leaves as word beats after the array access time. Each command finishes with a single done pulse that carries a status code.

The emulator applies the rules that make flash different from RAM. Erase works only on a whole block and sets every bit of it to one. Program can only clear bits. A page accepts one program between erases. Each class of operation has its own busy time. Every block counts its erases, and a block that reaches the wear limit is retired: later program and erase requests to it fail.

Block, page and word counts must be powers of two. The word address inside the array is the block index, then the page index, then the word index, with the block index most significant. The reset state is a freshly erased array with every erase count at zero.

Top module: `nand_emu`

## Requirements
- R1: After reset, busy and done are low, cmd_ready is high, and every word of every page reads as all ones.
- R2: A read (cmd_op 0) holds busy for T_READ cycles, then gives NWORD beats with rd_valid high in word order 0 upward, then pulses done with status 0.
- R3: A program (cmd_op 1) takes NWORD beats on wr_data, one for each cycle with wr_valid high. Each stored word becomes its old value ANDed with the beat, so an erased page reads back the data written. Other pages of the block do not change.
- R4: A program to a page already programmed since its block's last erase returns status 1 and leaves the page contents unchanged.
- R5: An erase (cmd_op 2) sets every word of the addressed block to all ones and makes its pages programmable again. Other blocks do not change.
- R6: busy is high from the cycle after a command is accepted until done. A command is accepted only while cmd_ready is high, and cmd_valid pulses while busy is high have no effect. A command held valid through the done cycle is accepted in that cycle.
- R7: done is high for exactly one cycle per command. busy is low in that cycle and status is valid in it.
- R8: busy lasts T_READ+NWORD cycles for a read, NWORD+T_PROG cycles for a successful program, and T_ERASE cycles for a successful erase.
- R9: A block that has completed WEAR_LIM erases is worn out. Erase and program requests to it return status 2 and leave the array unchanged. A failed erase holds busy for one cycle and a failed program for NWORD+1 cycles. Reads of the block still work.
- R10: cmd_op 3 is illegal. It returns status 3 after one busy cycle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 illegal |
| cmd_blk | input | $clog2(NBLK) | Block index |
| cmd_page | input | $clog2(NPG) | Page index within the block |
| wr_valid | input | 1 | Program data beat present |
| wr_data | input | WW | Program data beat |
| rd_valid | output | 1 | Read data beat present |
| rd_data | output | WW | Read data beat |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 page not erased, 2 block worn out, 3 illegal command |

## Verification
Completion of one command and acceptance of the next fall in the same cycle: done drops busy, so a command held valid right through an erase is taken on the done edge. The bench holds cmd_valid high across an erase and changes the command fields to a read while busy is high. It then expects busy to be high one cycle after done and the read data to show the erased block. A second coincidence occurs when the erase that reaches the wear limit completes normally while retiring the block. The bench judges this from the status of that erase and of the request that follows it.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_ILL = 2'd3} op_e;
    typedef enum logic [1:0] {ST_OK = 2'd0, ST_DIRTY = 2'd1, ST_WORN = 2'd2, ST_ILLOP = 2'd3} stat_e;
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_OUT} fsm_e;
endpackage

// File: rtl/nand_emu_array.sv
module nand_emu_array #(
    parameter int NBLK  = 4,
    parameter int NPG   = 8,
    parameter int NWORD = 16,
    parameter int WW    = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(NBLK*NPG*NWORD)-1:0]  addr,
    input  logic [WW-1:0]                      wr_data,
    input  logic                               er_en,
    input  logic [$clog2(NBLK)-1:0]            er_blk,
    output logic [WW-1:0]                      rd_data
);
    localparam int DEPTH = NBLK * NPG * NWORD;
    localparam int SH    = $clog2(NPG * NWORD);

    logic [WW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (er_en) begin
            for (int i = 0; i < DEPTH; i++)
                if ((i >> SH) == int'(er_blk)) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[addr] <= mem_q[addr] & wr_data;
        end
    end

    assign rd_data = mem_q[addr];
endmodule

// File: rtl/nand_emu_blkinfo.sv
module nand_emu_blkinfo #(
    parameter int NBLK     = 4,
    parameter int NPG      = 8,
    parameter int WEAR_LIM = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NBLK)-1:0] q_blk,
    input  logic [$clog2(NPG)-1:0]  q_page,
    output logic                    q_worn,
    output logic                    q_dirty,
    input  logic                    er_en,
    input  logic [$clog2(NBLK)-1:0] er_blk,
    input  logic                    mk_en,
    input  logic [$clog2(NBLK)-1:0] mk_blk,
    input  logic [$clog2(NPG)-1:0]  mk_page
);
    localparam int CW = $clog2(WEAR_LIM + 1);

    logic [CW-1:0]  wear_q  [NBLK];
    logic [NPG-1:0] dirty_q [NBLK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                wear_q[b]  <= '0;
                dirty_q[b] <= '0;
            end
        end else begin
            if (er_en) begin
                dirty_q[er_blk] <= '0;
                if (wear_q[er_blk] != CW'(WEAR_LIM)) wear_q[er_blk] <= wear_q[er_blk] + 1'b1;
            end
            if (mk_en) dirty_q[mk_blk][mk_page] <= 1'b1;
        end
    end

    assign q_worn  = (wear_q[q_blk] >= CW'(WEAR_LIM));
    assign q_dirty = dirty_q[q_blk][q_page];
endmodule

// File: rtl/nand_emu_ctrl.sv
module nand_emu_ctrl
    import nand_emu_pkg::*;
#(
    parameter int NBLK    = 4,
    parameter int NPG     = 8,
    parameter int NWORD   = 16,
    parameter int T_READ  = 4,
    parameter int T_PROG  = 20,
    parameter int T_ERASE = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  op_e                      cmd_op,
    input  logic [$clog2(NBLK)-1:0]  cmd_blk,
    input  logic [$clog2(NPG)-1:0]   cmd_page,
    input  logic                     wr_valid,
    input  logic                     q_worn,
    input  logic                     q_dirty,
    output logic [$clog2(NBLK)-1:0]  cur_blk,
    output logic [$clog2(NPG)-1:0]   cur_page,
    output logic [$clog2(NWORD)-1:0] cur_idx,
    output logic                     wr_en,
    output logic                     mk_en,
    output logic                     er_en,
    output logic                     busy,
    output logic                     rd_valid,
    output logic                     done,
    output stat_e                    status
);
    localparam int BW   = $clog2(NBLK);
    localparam int PW   = $clog2(NPG);
    localparam int IW   = $clog2(NWORD);
    localparam int TMAX = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                             : ((T_PROG > T_READ) ? T_PROG : T_READ);
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        fsm_e          state;
        op_e           op;
        logic [BW-1:0] blk;
        logic [PW-1:0] page;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        stat_e         st;
        logic          done;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            S_IDLE: if (cmd_valid) begin
                r_d.op   = cmd_op;
                r_d.blk  = cmd_blk;
                r_d.page = cmd_page;
                r_d.idx  = '0;
                r_d.cnt  = '0;
                r_d.st   = ST_OK;
                unique case (cmd_op)
                    OP_READ: begin
                        r_d.state = S_WAIT;
                        r_d.cnt   = CW'(T_READ - 1);
                    end
                    OP_PROG: begin
                        r_d.state = S_LOAD;
                        if (q_worn)       r_d.st = ST_WORN;
                        else if (q_dirty) r_d.st = ST_DIRTY;
                    end
                    OP_ERASE: begin
                        r_d.state = S_WAIT;
                        if (q_worn) r_d.st  = ST_WORN;
                        else        r_d.cnt = CW'(T_ERASE - 1);
                    end
                    default: begin
                        r_d.state = S_WAIT;
                        r_d.st    = ST_ILLOP;
                    end
                endcase
            end
            S_LOAD: if (wr_valid) begin
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx == '1) begin
                    r_d.state = S_WAIT;
                    r_d.cnt   = (r_q.st == ST_OK) ? CW'(T_PROG - 1) : '0;
                end
            end
            S_WAIT: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.op == OP_READ) begin
                    r_d.state = S_OUT;
                    r_d.idx   = '0;
                end else begin
                    r_d.state = S_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx == '1) begin
                    r_d.state = S_IDLE;
                    r_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: S_IDLE, op: OP_READ, st: ST_OK, default: '0};
        else        r_q <= r_d;
    end

    assign cur_blk  = r_q.blk;
    assign cur_page = r_q.page;
    assign cur_idx  = r_q.idx;
    assign wr_en    = (r_q.state == S_LOAD) && wr_valid && (r_q.st == ST_OK);
    assign mk_en    = wr_en && (r_q.idx == '1);
    assign er_en    = (r_q.state == S_WAIT) && (r_q.cnt == '0) && (r_q.op == OP_ERASE) && (r_q.st == ST_OK);
    assign busy     = (r_q.state != S_IDLE);
    assign rd_valid = (r_q.state == S_OUT);
    assign done     = r_q.done;
    assign status   = r_q.st;
endmodule

// File: rtl/nand_emu.sv
module nand_emu
    import nand_emu_pkg::*;
#(
    parameter int NBLK     = 4,
    parameter int NPG      = 8,
    parameter int NWORD    = 16,
    parameter int WW       = 32,
    parameter int T_READ   = 4,
    parameter int T_PROG   = 20,
    parameter int T_ERASE  = 100,
    parameter int WEAR_LIM = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [1:0]              cmd_op,
    input  logic [$clog2(NBLK)-1:0] cmd_blk,
    input  logic [$clog2(NPG)-1:0]  cmd_page,
    input  logic                    wr_valid,
    input  logic [WW-1:0]           wr_data,
    output logic                    rd_valid,
    output logic [WW-1:0]           rd_data,
    output logic                    busy,
    output logic                    done,
    output logic [1:0]              status
);
    localparam int BW = $clog2(NBLK);
    localparam int PW = $clog2(NPG);
    localparam int IW = $clog2(NWORD);

    logic [BW-1:0] cur_blk;
    logic [PW-1:0] cur_page;
    logic [IW-1:0] cur_idx;
    logic          wr_en, mk_en, er_en, q_worn, q_dirty, busy_w;
    stat_e         st_w;

    nand_emu_ctrl #(
        .NBLK(NBLK), .NPG(NPG), .NWORD(NWORD),
        .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid && !busy_w), .cmd_op(op_e'(cmd_op)),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page), .wr_valid(wr_valid),
        .q_worn(q_worn), .q_dirty(q_dirty),
        .cur_blk(cur_blk), .cur_page(cur_page), .cur_idx(cur_idx),
        .wr_en(wr_en), .mk_en(mk_en), .er_en(er_en),
        .busy(busy_w), .rd_valid(rd_valid), .done(done), .status(st_w)
    );

    nand_emu_blkinfo #(.NBLK(NBLK), .NPG(NPG), .WEAR_LIM(WEAR_LIM)) info_i (
        .clk(clk), .rst_n(rst_n),
        .q_blk(cmd_blk), .q_page(cmd_page), .q_worn(q_worn), .q_dirty(q_dirty),
        .er_en(er_en), .er_blk(cur_blk),
        .mk_en(mk_en), .mk_blk(cur_blk), .mk_page(cur_page)
    );

    nand_emu_array #(.NBLK(NBLK), .NPG(NPG), .NWORD(NWORD), .WW(WW)) array_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr({cur_blk, cur_page, cur_idx}), .wr_data(wr_data),
        .er_en(er_en), .er_blk(cur_blk), .rd_data(rd_data)
    );

    assign busy      = busy_w;
    assign cmd_ready = !busy_w;
    assign status    = st_w;
endmodule

// File: rtl/nand_emu_chk.sv
module nand_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic busy,
    input logic done,
    input logic rd_valid
);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    p_done_idle_r7:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_ready) |=> busy);
    p_busy_end_r6:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
    p_rd_in_op_r2:    assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> busy);
endmodule

bind nand_emu nand_emu_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .rd_valid(rd_valid)
);

// File: tb/nand_emu_tb_top.sv
module nand_emu_tb_top;
    localparam int TR = 3, TP = 5, TE = 9, WL = 3, NW = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0, wr_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [1:0]  cmd_blk = '0;
    logic [2:0]  cmd_page = '0;
    logic [31:0] wr_data = '0;
    logic        cmd_ready, rd_valid, busy, done;
    logic [31:0] rd_data;
    logic [1:0]  status;

    int total = 0, bad = 0;
    logic [31:0] wbuf [NW];
    logic [31:0] rbuf [NW];
    int nrd, busy_n;
    logic [1:0] got_st;
    logic done_after;

    always #10 clk = ~clk;

    nand_emu #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .WEAR_LIM(WL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .status(status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic collect(input logic [1:0] op);
        int beat = 0;
        nrd = 0; busy_n = 0;
        while (1) begin
            if (done) begin got_st = status; break; end
            if (busy) busy_n++;
            if (rd_valid && nrd < NW) begin rbuf[nrd] = rd_data; nrd++; end
            if (op == 2'd1 && beat < NW) begin wr_valid = 1'b1; wr_data = wbuf[beat]; beat++; end
            else wr_valid = 1'b0;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        @(negedge clk);
        done_after = done;
    endtask

    task automatic do_op(input logic [1:0] op, input int blk, input int page);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_blk = 2'(blk); cmd_page = 3'(page);
        @(negedge clk);
        cmd_valid = 1'b0;
        collect(op);
    endtask

    task automatic check_page(input string req, input logic [31:0] base, input bit ones);
        for (int i = 0; i < NW; i++)
            check(rbuf[i] === (ones ? 32'hFFFF_FFFF : base ^ 32'(i * 32'h0101_0101)), req, rbuf[i],
                  ones ? 32'hFFFF_FFFF : base ^ 32'(i * 32'h0101_0101));
    endtask

    task automatic fill(input logic [31:0] base);
        for (int i = 0; i < NW; i++) wbuf[i] = base ^ 32'(i * 32'h0101_0101);
    endtask

    task automatic t_reset;
        check(busy === 1'b0 && done === 1'b0 && cmd_ready === 1'b1, "R1 idle after reset",
              {29'd0, busy, done, cmd_ready}, 32'd1);
        do_op(2'd0, 0, 0);
        check(nrd == NW, "R2 beat count", nrd, NW);
        check_page("R1 erased contents", 0, 1'b1);
        check(got_st == 2'd0, "R2 read status", got_st, 0);
        check(busy_n == TR + NW, "R8 read busy", busy_n, TR + NW);
        check(done_after === 1'b0, "R7 done one cycle", done_after, 0);
    endtask

    task automatic t_program;
        fill(32'h5A3C_0F96);
        do_op(2'd1, 1, 2);
        check(got_st == 2'd0, "R3 program status", got_st, 0);
        check(busy_n == NW + TP, "R8 program busy", busy_n, NW + TP);
        do_op(2'd0, 1, 2);
        check_page("R3 read back", 32'h5A3C_0F96, 1'b0);
        do_op(2'd0, 1, 3);
        check_page("R3 neighbour page untouched", 0, 1'b1);
        fill(32'h0000_FFFF);
        do_op(2'd1, 1, 2);
        check(got_st == 2'd1, "R4 reprogram status", got_st, 1);
        check(busy_n == NW + 1, "R4 reprogram busy", busy_n, NW + 1);
        do_op(2'd0, 1, 2);
        check_page("R4 page unchanged", 32'h5A3C_0F96, 1'b0);
    endtask

    task automatic t_erase;
        fill(32'hC001_D00D);
        do_op(2'd1, 2, 0);
        do_op(2'd2, 1, 0);
        check(got_st == 2'd0, "R5 erase status", got_st, 0);
        check(busy_n == TE, "R8 erase busy", busy_n, TE);
        do_op(2'd0, 1, 2);
        check_page("R5 block erased", 0, 1'b1);
        do_op(2'd0, 2, 0);
        check_page("R5 other block kept", 32'hC001_D00D, 1'b0);
        fill(32'h1234_5678);
        do_op(2'd1, 1, 2);
        check(got_st == 2'd0, "R5 programmable after erase", got_st, 0);
        do_op(2'd0, 1, 2);
        check_page("R5 reprogram data", 32'h1234_5678, 1'b0);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_blk = 2'd2; cmd_page = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R6 busy during erase", busy, 1);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_blk = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        collect(2'd2);
        check(busy === 1'b0 && rd_valid === 1'b0, "R6 busy-time command ignored", {busy, rd_valid}, 0);
        repeat (TR + 2) @(negedge clk);
        check(busy === 1'b0 && rd_valid === 1'b0, "R6 no late start", {busy, rd_valid}, 0);
    endtask

    task automatic t_back_to_back;
        fill(32'h0F0F_0F0F);
        do_op(2'd1, 2, 1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_blk = 2'd2; cmd_page = '0;
        @(negedge clk);
        cmd_op = 2'd0; cmd_page = 3'd1;
        while (!done) @(negedge clk);
        check(status == 2'd0, "R7 status in done cycle", status, 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy === 1'b1, "R6 accept in done cycle", busy, 1);
        collect(2'd0);
        check(nrd == NW && got_st == 2'd0, "R6 chained read", nrd, NW);
        check_page("R5 chained read erased", 0, 1'b1);
    endtask

    task automatic t_wear;
        for (int k = 0; k < WL; k++) begin
            do_op(2'd2, 3, 0);
            check(got_st == 2'd0, "R9 erase below limit", got_st, 0);
        end
        do_op(2'd2, 3, 0);
        check(got_st == 2'd2, "R9 worn erase status", got_st, 2);
        check(busy_n == 1, "R9 worn erase busy", busy_n, 1);
        fill(32'h0000_0000);
        do_op(2'd1, 3, 0);
        check(got_st == 2'd2, "R9 worn program status", got_st, 2);
        check(busy_n == NW + 1, "R9 worn program busy", busy_n, NW + 1);
        do_op(2'd0, 3, 0);
        check(got_st == 2'd0, "R9 read of worn block", got_st, 0);
        check_page("R9 worn block unchanged", 0, 1'b1);
    endtask

    task automatic t_illegal;
        do_op(2'd3, 0, 0);
        check(got_st == 2'd3, "R10 illegal status", got_st, 3);
        check(busy_n == 1, "R10 illegal busy", busy_n, 1);
        do_op(2'd0, 0, 0);
        check_page("R10 array untouched", 0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_busy_ignore();
        t_back_to_back();
        t_wear();
        t_illegal();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog actual=hung expected=idle");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule